// File: doc/BRIEF.md
# SEC-DED Read Correction and Write-Back Merge Datapath

This block sits on the read side of a 64-bit memory channel whose words carry 8 check bits. A word fetched from memory is captured together with its stored check bits into a pair of input registers. The check bits are regenerated from the captured data and combined with the stored ones to form a syndrome. The syndrome fixes any single-bit error and reports a word that cannot be repaired.

The repaired word is then placed in an output register, which holds it for the system side. That output is driven only while its active-low enable is asserted.

The same repaired word also feeds a byte-wise merge multiplexer that builds the word written back to memory. Each byte is taken either from the repaired read data or from a write-buffer word. The eight byte selects come from one of two sources: the external byte-enable pins, or the byte enables stored with the buffered write data. This supports scrub-style write-back as well as read-modify-write merging of partial writes.

Top module: `ecc_rdpath`

## Requirements
- R1: On a rising clock edge with `in_le_i` high, the input registers load `mem_data_i` and `mem_chk_i`. With `in_le_i` low they keep their contents, whatever the memory inputs do.
- R2: Each data bit i has an 8-bit column. Column i is entry i of the list of all 8-bit values of weight 3 in ascending numeric order, followed by the weight-5 values in ascending order. Check bit k has column `1<<k`. Generated check bit r is the XOR of the data bits whose column has bit r set. The syndrome is the generated check bits XOR the received check bits.
- R3: A zero syndrome passes the data unchanged, with `sgl_err_o` and `mul_err_o` both low.
- R4: A syndrome equal to the column of data bit i inverts bit i of the repaired word and raises `sgl_err_o`.
- R5: A syndrome equal to a check-bit column leaves the data unchanged and raises `sgl_err_o`.
- R6: Any other nonzero syndrome, such as a two-bit error, raises `mul_err_o` with `sgl_err_o` low and passes the data uncorrected.
- R7: On a rising edge with `out_le_i` high and `rd_path_sel_i` low, the output register loads the repaired word and its multiple-error status. Otherwise it holds them.
- R8: While `out_oe_n_i` is low, `sys_data_o` shows the output register and `sys_valid_o` is high unless the held word had a multiple error. While `out_oe_n_i` is high, `sys_data_o` is zero and `sys_valid_o` is low.
- R9: Byte b of `mem_wb_o` (bits 8b+7..8b) is the repaired byte when select bit b is 1, and the `wbuf_data_i` byte when it is 0.
- R10: The byte selects are `byte_en_i` when `wb_sel_i` is 0 and `wbuf_be_i` when it is 1. Setting `wb_sel_i`=0 with `byte_en_i`=8'hFF writes back the whole repaired word.
- R11: After reset, both register stages are zero, so the flags are low, `sys_data_o` is zero and `sys_valid_o` is high while the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_data_i | input | 64 | Data word from memory |
| mem_chk_i | input | 8 | Stored check bits from memory |
| in_le_i | input | 1 | Input register load enable |
| out_le_i | input | 1 | Output register load enable |
| rd_path_sel_i | input | 1 | Read path select; low routes through the output register |
| out_oe_n_i | input | 1 | Active-low system output enable |
| wb_sel_i | input | 1 | Byte-select source: 0 external enables, 1 buffered enables |
| byte_en_i | input | 8 | External byte selects |
| wbuf_data_i | input | 64 | Buffered write data |
| wbuf_be_i | input | 8 | Byte enables stored with the buffered write data |
| sgl_err_o | output | 1 | Single-bit error corrected |
| mul_err_o | output | 1 | Uncorrectable error detected |
| sys_data_o | output | 64 | Repaired word toward the system side |
| sys_valid_o | output | 1 | System output enabled and free of multiple error |
| mem_wb_o | output | 64 | Merged write-back word toward memory |

## Verification
A wrong column in the generator or the corrector shows up one edge after the input load. The flags and the merged write-back word disagree with a syndrome computed independently, and a repair lands on the wrong bit. A stale or wrongly enabled register stage shows up at the system output one edge after the output load, because the bench then reads a word other than the one last captured under the selected path. Faults in byte selection appear at once as the wrong bytes on the write-back word.

// File: rtl/ecc_rdpath_pkg.sv
package ecc_rdpath_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int BYTE_W = 8;
    localparam int NBYTES = DATA_W / BYTE_W;

    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [DATA_W-1:0] word_t;

    // Odd-weight column for data bit idx: weight-3 values first, then
    // weight-5 (then weight-7), each group in ascending numeric order.
    function automatic chk_t data_column(input int idx);
        chk_t res;
        chk_t cand;
        int   seen;
        res  = '0;
        seen = 0;
        for (int w = 3; w < CHK_W; w += 2) begin
            for (int v = 0; v < (1 << CHK_W); v++) begin
                cand = chk_t'(v);
                if ($countones(cand) == w) begin
                    if (seen == idx) res = cand;
                    seen++;
                end
            end
        end
        return res;
    endfunction

    typedef struct packed {
        word_t mem_data;
        chk_t  mem_chk;
        word_t out_data;
        logic  out_mul;
    } state_t;

endpackage

// File: rtl/ecc_rdpath_chkgen.sv
module ecc_rdpath_chkgen
    import ecc_rdpath_pkg::*;
(
    input  word_t data_i,
    output chk_t  chk_o
);

    chk_t term [DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam chk_t COL = data_column(i);
        assign term[i] = data_i[i] ? COL : '0;
    end

    always_comb begin
        chk_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            chk_o = chk_o ^ term[i];
        end
    end

endmodule

// File: rtl/ecc_rdpath_corrector.sv
module ecc_rdpath_corrector
    import ecc_rdpath_pkg::*;
(
    input  word_t data_i,
    input  chk_t  syn_i,
    output word_t data_o,
    output logic  sgl_o,
    output logic  mul_o
);

    logic [DATA_W-1:0] dhit;
    logic [CHK_W-1:0]  chit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dmatch
        localparam chk_t COL = data_column(i);
        assign dhit[i] = (syn_i == COL);
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_cmatch
        assign chit[k] = (syn_i == chk_t'(1 << k));
    end

    assign data_o = data_i ^ dhit;
    assign sgl_o  = |{dhit, chit};
    assign mul_o  = (syn_i != '0) && !sgl_o;

endmodule

// File: rtl/ecc_rdpath_merge.sv
module ecc_rdpath_merge
    import ecc_rdpath_pkg::*;
(
    input  word_t             corr_i,
    input  word_t             wbuf_i,
    input  logic [NBYTES-1:0] byte_en_i,
    input  logic [NBYTES-1:0] wbuf_be_i,
    input  logic              wb_sel_i,
    output word_t             wb_o
);

    logic [NBYTES-1:0] sel;

    assign sel = wb_sel_i ? wbuf_be_i : byte_en_i;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign wb_o[b*BYTE_W +: BYTE_W] = sel[b] ? corr_i[b*BYTE_W +: BYTE_W]
                                                 : wbuf_i[b*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/ecc_rdpath.sv
module ecc_rdpath
    import ecc_rdpath_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic [CHK_W-1:0]  mem_chk_i,
    input  logic              in_le_i,
    input  logic              out_le_i,
    input  logic              rd_path_sel_i,
    input  logic              out_oe_n_i,
    input  logic              wb_sel_i,
    input  logic [NBYTES-1:0] byte_en_i,
    input  logic [DATA_W-1:0] wbuf_data_i,
    input  logic [NBYTES-1:0] wbuf_be_i,
    output logic              sgl_err_o,
    output logic              mul_err_o,
    output logic [DATA_W-1:0] sys_data_o,
    output logic              sys_valid_o,
    output logic [DATA_W-1:0] mem_wb_o
);

    state_t st_d, st_q;
    chk_t   gen_w;
    chk_t   syn_w;
    word_t  corr_w;
    logic   sgl_w;
    logic   mul_w;

    ecc_rdpath_chkgen i_chkgen (
        .data_i (st_q.mem_data),
        .chk_o  (gen_w)
    );

    assign syn_w = gen_w ^ st_q.mem_chk;

    ecc_rdpath_corrector i_corr (
        .data_i (st_q.mem_data),
        .syn_i  (syn_w),
        .data_o (corr_w),
        .sgl_o  (sgl_w),
        .mul_o  (mul_w)
    );

    ecc_rdpath_merge i_merge (
        .corr_i    (corr_w),
        .wbuf_i    (wbuf_data_i),
        .byte_en_i (byte_en_i),
        .wbuf_be_i (wbuf_be_i),
        .wb_sel_i  (wb_sel_i),
        .wb_o      (mem_wb_o)
    );

    always_comb begin
        st_d = st_q;
        if (in_le_i) begin
            st_d.mem_data = mem_data_i;
            st_d.mem_chk  = mem_chk_i;
        end
        if (out_le_i && !rd_path_sel_i) begin
            st_d.out_data = corr_w;
            st_d.out_mul  = mul_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sgl_err_o   = sgl_w;
    assign mul_err_o   = mul_w;
    assign sys_data_o  = out_oe_n_i ? '0 : st_q.out_data;
    assign sys_valid_o = !out_oe_n_i && !st_q.out_mul;

endmodule

// File: rtl/ecc_rdpath_chk.sv
module ecc_rdpath_chk
    import ecc_rdpath_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_le_i,
    input logic              out_le_i,
    input logic              rd_path_sel_i,
    input logic              out_oe_n_i,
    input logic              wb_sel_i,
    input logic [NBYTES-1:0] byte_en_i,
    input word_t             data_q,
    input word_t             out_q,
    input chk_t              syn,
    input word_t             corr,
    input logic              sgl,
    input logic              mul,
    input word_t             sys_data_o,
    input logic              sys_valid_o,
    input word_t             mem_wb_o
);

    // R1
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_le_i |=> $stable(data_q));

    // R3
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syn == '0) |-> (!sgl && !mul && corr == data_q));

    // R4
    one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sgl |-> ($countones(corr ^ data_q) <= 1));

    // R6
    sgl_mul_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sgl && mul));

    // R6
    mul_nocorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul |-> (corr == data_q));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_le_i || rd_path_sel_i) |=> $stable(out_q));

    // R8
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_oe_n_i |-> (sys_data_o == '0 && !sys_valid_o));

    // R10
    full_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_sel_i && (&byte_en_i)) |-> (mem_wb_o == corr));

endmodule

bind ecc_rdpath ecc_rdpath_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_le_i       (in_le_i),
    .out_le_i      (out_le_i),
    .rd_path_sel_i (rd_path_sel_i),
    .out_oe_n_i    (out_oe_n_i),
    .wb_sel_i      (wb_sel_i),
    .byte_en_i     (byte_en_i),
    .data_q        (st_q.mem_data),
    .out_q         (st_q.out_data),
    .syn           (syn_w),
    .corr          (corr_w),
    .sgl           (sgl_w),
    .mul           (mul_w),
    .sys_data_o    (sys_data_o),
    .sys_valid_o   (sys_valid_o),
    .mem_wb_o      (mem_wb_o)
);

// File: tb/test_ecc_rdpath.sv
module test_ecc_rdpath;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] mem_data = '0;
    logic [7:0]  mem_chk = '0;
    logic        in_le = 1'b0;
    logic        out_le = 1'b0;
    logic        rd_sel = 1'b0;
    logic        oe_n = 1'b0;
    logic        wb_sel = 1'b0;
    logic [7:0]  byte_en = 8'hFF;
    logic [63:0] wbuf_data = '0;
    logic [7:0]  wbuf_be = '0;
    logic        sgl_err, mul_err, sys_valid;
    logic [63:0] sys_data, mem_wb;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] corr;
        logic        sgl;
        logic        mul;
        logic        valid;
        logic [63:0] wb;
        string       tag;
        string       wbtag;
    } exp_t;

    exp_t exp_q[$];
    event mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_rdpath i_ecc_rdpath (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_data_i    (mem_data),
        .mem_chk_i     (mem_chk),
        .in_le_i       (in_le),
        .out_le_i      (out_le),
        .rd_path_sel_i (rd_sel),
        .out_oe_n_i    (oe_n),
        .wb_sel_i      (wb_sel),
        .byte_en_i     (byte_en),
        .wbuf_data_i   (wbuf_data),
        .wbuf_be_i     (wbuf_be),
        .sgl_err_o     (sgl_err),
        .mul_err_o     (mul_err),
        .sys_data_o    (sys_data),
        .sys_valid_o   (sys_valid),
        .mem_wb_o      (mem_wb)
    );

    // R2: column list as stated in the requirement
    function automatic logic [7:0] hcol(input int idx);
        int n = 0;
        logic [7:0] r = '0;
        for (int w = 3; w < 8; w += 2)
            for (int v = 0; v < 256; v++)
                if ($countones(v[7:0]) == w) begin
                    if (n == idx) r = v[7:0];
                    n++;
                end
        return r;
    endfunction

    function automatic logic [7:0] encode(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) if (d[i]) c = c ^ hcol(i);
        return c;
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic do_case(input logic [63:0] d, input logic [63:0] dflip,
                           input logic [7:0] cflip, input logic wsel,
                           input logic [7:0] be, input logic [63:0] wbuf,
                           input logic [7:0] wbe, input string tag, input string wbtag);
        exp_t e;
        int nerr;
        logic [7:0] sel;
        nerr = $countones(dflip) + $countones(cflip);
        e.corr  = (nerr <= 1) ? d : (d ^ dflip);
        e.sgl   = (nerr == 1);
        e.mul   = (nerr == 2);
        e.valid = !e.mul;
        sel = wsel ? wbe : be;
        for (int b = 0; b < 8; b++)
            e.wb[b*8 +: 8] = sel[b] ? e.corr[b*8 +: 8] : wbuf[b*8 +: 8];
        e.tag = tag;
        e.wbtag = wbtag;
        exp_q.push_back(e);
        @(negedge clk);
        mem_data = d ^ dflip;
        mem_chk = encode(d) ^ cflip;
        in_le = 1; out_le = 0; rd_sel = 0; oe_n = 0;
        wb_sel = wsel; byte_en = be; wbuf_data = wbuf; wbuf_be = wbe;
        @(negedge clk);
        in_le = 0; out_le = 1;
        @(negedge clk);
        out_le = 0;
        -> mon_ev;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(mon_ev);
            e = exp_q.pop_front();
            cmp(e.tag, "sys_data", sys_data, e.corr);
            cmp(e.tag, "sgl_err", 64'(sgl_err), 64'(e.sgl));
            cmp(e.tag, "mul_err", 64'(mul_err), 64'(e.mul));
            cmp(e.tag, "sys_valid", 64'(sys_valid), 64'(e.valid));
            cmp(e.wbtag, "mem_wb", mem_wb, e.wb);
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : driver
        logic [63:0] d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        cmp("R11", "sys_data", sys_data, 64'h0);
        cmp("R11", "sgl_err", 64'(sgl_err), 64'h0);
        cmp("R11", "mul_err", 64'(mul_err), 64'h0);
        cmp("R11", "sys_valid", 64'(sys_valid), 64'h1);
        cmp("R11", "mem_wb", mem_wb, 64'h0);

        // R2 R3 R10: clean word, full write-back
        do_case(64'h0123_4567_89AB_CDEF, 64'h0, 8'h0, 0, 8'hFF, 64'hFFFF_0000_FFFF_0000, 8'h00, "R3", "R10");
        // R4 R9: data bit 0 flipped, low four bytes from the repaired word
        do_case(64'hDEAD_BEEF_CAFE_F00D, 64'h1, 8'h0, 0, 8'h0F, 64'h1111_2222_3333_4444, 8'hF0, "R4", "R9");
        // R4 R10: data bit 63 flipped, selects from buffered enables
        do_case(64'h5A5A_A5A5_0F0F_F0F0, 64'h8000_0000_0000_0000, 8'h0, 1, 8'h00, 64'h7777_8888_9999_AAAA, 8'hA5, "R4", "R10");
        // R4: data bit 31
        do_case(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000, 8'h0, 0, 8'hFF, 64'h0, 8'h00, "R4", "R10");
        // R5: check bit 7 and check bit 0
        do_case(64'h1357_9BDF_2468_ACE0, 64'h0, 8'h80, 0, 8'h3C, 64'hABCD_EF01_2345_6789, 8'h00, "R5", "R9");
        do_case(64'h0, 64'h0, 8'h01, 1, 8'hFF, 64'hCCCC_CCCC_CCCC_CCCC, 8'h0F, "R5", "R10");
        // R6: double data error, and data plus check error
        do_case(64'h0F1E_2D3C_4B5A_6978, 64'h0000_0100_0000_0020, 8'h0, 0, 8'hFF, 64'h0, 8'h00, "R6", "R10");
        do_case(64'h8421_8421_8421_8421, 64'h0000_0000_0001_0000, 8'h10, 1, 8'h00, 64'h55AA_55AA_55AA_55AA, 8'h81, "R6", "R10");
        // R8: a clean word restores valid after a multiple error
        do_case(64'hCAFE_BABE_0000_1111, 64'h0, 8'h0, 0, 8'hFF, 64'h0, 8'h00, "R8", "R10");

        // R7: with the read path selected away the output register holds
        d2 = 64'h2222_3333_4444_5555;
        @(negedge clk);
        mem_data = d2; mem_chk = encode(d2); in_le = 1; out_le = 1; rd_sel = 1;
        @(negedge clk);
        in_le = 0;
        @(negedge clk);
        cmp("R7", "sys_data held", sys_data, 64'hCAFE_BABE_0000_1111);
        out_le = 0; rd_sel = 0;

        // R1: input register holds while memory inputs change
        mem_data = 64'hFFFF_0000_1234_9876; mem_chk = 8'h3A;
        @(negedge clk);
        out_le = 1;
        @(negedge clk);
        out_le = 0;
        cmp("R1", "sys_data after hold", sys_data, d2);
        cmp("R1", "sgl_err after hold", 64'(sgl_err), 64'h0);

        // R8: output disabled
        oe_n = 1;
        @(negedge clk);
        cmp("R8", "sys_data disabled", sys_data, 64'h0);
        cmp("R8", "sys_valid disabled", 64'(sys_valid), 64'h0);
        oe_n = 0;
        @(negedge clk);
        cmp("R8", "sys_data re-enabled", sys_data, d2);

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule